// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the serial slave through which a host programs the mode-control registers of a data-converter datapath. The host selects the port with an active-low chip select and clocks bits in on a serial clock. Each transfer opens with an instruction byte that carries the direction, the number of data bytes and the start register. One to four data bytes follow, and the register address steps after each byte. The decoded register fields leave the block as parallel configuration outputs: interpolation rate, modulation select, input coding and input port mode.

Register 0 holds the port's own format: bit 7 moves read data from the separate output line onto the bidirectional data line, and bit 6 selects least-significant-bit-first order. A write to register 0 takes effect on its last bit, so any later bytes in the same transfer use the new bit order and the new address direction. All serial inputs are sampled by the system clock, and edges on the serial clock are detected in that domain.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset every register reads 0, so the port is MSB-first with read data on `sdo`, `sdio_oe` is 0 and all configuration outputs are 0.
- R2: The instruction byte has bit 7 = read(1)/write(0), bits 6:5 = data byte count minus one and bits 4:0 = start address; a one-byte write to register 1 puts bits 7:6 on `interp_rate` (00=1x, 01=2x, 10=4x, 11=8x) and bits 5:4 on `mod_mode`.
- R3: Register 2 bit 7 drives `data_binary` and bit 6 drives `one_port`.
- R4: In MSB-first mode each data byte is shifted MSB first and the address decrements after each data byte.
- R5: In LSB-first mode (register 0 bit 6 = 1) instruction and data bytes are shifted LSB first and the address increments after each data byte.
- R6: A write to register 0 changes bit order and address direction at once; the remaining bytes of the same transfer use the new format.
- R7: With register 0 bit 7 = 0, read data appears on `sdo`, one bit per serial clock falling edge, and `sdio_oe` stays 0.
- R8: With register 0 bit 7 = 1, read data is driven on `sdio_out` with `sdio_oe` = 1 during the data phase, and `sdo` stays 0.
- R9: Raising `cs_n` aborts the transfer; a partial instruction or a partial data byte changes no register, and the next transfer starts with a fresh instruction.
- R10: Writes to addresses 4 to 31 change no register; reads there return 0.
- R11: Bytes clocked after the counted data bytes are ignored until `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, sampled by clk |
| cs_n | input | 1 | Active-low chip select |
| sdio_in | input | 1 | Serial data in (bidirectional line, input side) |
| sdio_out | output | 1 | Serial read data for the bidirectional line |
| sdio_oe | output | 1 | Drive enable for the bidirectional line |
| sdo | output | 1 | Separate serial read data line |
| interp_rate | output | 2 | Interpolation rate select |
| mod_mode | output | 2 | Modulation mode select |
| data_binary | output | 1 | Input coding: 1 = straight binary |
| one_port | output | 1 | Input port mode: 1 = single interleaved port |

## Verification
The assertions assume that `sclk`, `cs_n` and `sdio_in` are already synchronous to `clk` and that each serial clock level lasts at least one system clock, so every serial edge is seen exactly once. The bench changes all three only on the falling edge of `clk` and holds each serial clock level for four system clocks. It also keeps `cs_n` low for whole bits except in the abort cases, where it stops between bits on purpose.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 5;
    localparam int LEN_W  = 2;
    localparam int CNT_W  = $clog2(DATA_W);

    localparam int CFG_ADDR  = 0;
    localparam int RATE_ADDR = 1;
    localparam int FMT_ADDR  = 2;
    localparam int BIT_BIDIR = 7;
    localparam int BIT_LSB   = 6;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_DATA  = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;

    typedef struct packed {
        logic             rd;
        logic [LEN_W-1:0] len_m1;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef struct packed {
        logic       bidir;
        logic       lsb_first;
        logic [1:0] interp;
        logic [1:0] modsel;
        logic       binary;
        logic       one_port;
    } cfg_t;

    function automatic byte_t shift_in(byte_t cur, logic d, logic lsb);
        return lsb ? {d, cur[DATA_W-1:1]} : {cur[DATA_W-2:0], d};
    endfunction

    function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] a, logic lsb);
        return lsb ? a + 1'b1 : a - 1'b1;
    endfunction

    function automatic logic bit_pick(byte_t b, logic [CNT_W-1:0] c, logic lsb);
        int idx;
        idx = lsb ? int'(c) : DATA_W - 1 - int'(c);
        return b[idx];
    endfunction

endpackage

// File: rtl/spi_cfg_edge.sv
module spi_cfg_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign rise = !cs_n &&  sclk && !sclk_q;
    assign fall = !cs_n && !sclk &&  sclk_q;

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
    import spi_cfg_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  byte_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output byte_t             rdata,
    output cfg_t              cfg
);
    byte_t regs_q [NUM_REGS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rst)                                regs_q[i] <= '0;
            else if (we && waddr == ADDR_W'(i))     regs_q[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (raddr == ADDR_W'(i)) rdata = regs_q[i];
    end

    assign cfg.bidir     = regs_q[CFG_ADDR][BIT_BIDIR];
    assign cfg.lsb_first = regs_q[CFG_ADDR][BIT_LSB];
    assign cfg.interp    = regs_q[RATE_ADDR][7:6];
    assign cfg.modsel    = regs_q[RATE_ADDR][5:4];
    assign cfg.binary    = regs_q[FMT_ADDR][7];
    assign cfg.one_port  = regs_q[FMT_ADDR][6];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
            // R2: a write strobe lands in exactly the addressed register
            a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
                (we && waddr == ADDR_W'(g)) |=> regs_q[g] == $past(wdata));
            // R9, R10: without a strobe for this address the register holds
            a_r10_hold_unaddressed: assert property (@(posedge clk) disable iff (rst)
                !(we && waddr == ADDR_W'(g)) |=> $stable(regs_q[g]));
        end
    endgenerate

endmodule

// File: rtl/spi_cfg_seq.sv
module spi_cfg_seq
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdio_in,
    input  logic              lsb_first,
    input  byte_t             rdata,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output byte_t             wdata,
    output logic              rd_active,
    output logic              out_bit
);
    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    byte_t             sh_q;
    logic              rd_q;
    logic [LEN_W-1:0]  left_q;
    logic [ADDR_W-1:0] addr_q;
    logic              out_q;

    byte_t  nxt_byte;
    instr_t instr;
    logic   last_bit;
    logic   lsb_next;

    assign nxt_byte = shift_in(sh_q, sdio_in, lsb_first);
    assign instr    = instr_t'(nxt_byte);
    assign last_bit = (cnt_q == CNT_W'(DATA_W - 1));
    assign we       = rise && phase_q == PH_DATA && !rd_q && last_bit;
    // a write to the format register steers the step that follows it
    assign lsb_next = (we && addr_q == ADDR_W'(CFG_ADDR)) ? nxt_byte[BIT_LSB] : lsb_first;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_INSTR;
            cnt_q   <= '0;
            sh_q    <= '0;
            rd_q    <= 1'b0;
            left_q  <= '0;
            addr_q  <= '0;
            out_q   <= 1'b0;
        end else if (cs_n) begin
            phase_q <= PH_INSTR;
            cnt_q   <= '0;
        end else begin
            if (rise && phase_q != PH_DONE) begin
                cnt_q <= cnt_q + 1'b1;
                sh_q  <= nxt_byte;
                if (last_bit) begin
                    if (phase_q == PH_INSTR) begin
                        rd_q    <= instr.rd;
                        left_q  <= instr.len_m1;
                        addr_q  <= instr.addr;
                        phase_q <= PH_DATA;
                    end else begin
                        addr_q <= step_addr(addr_q, lsb_next);
                        if (left_q == '0) phase_q <= PH_DONE;
                        else              left_q  <= left_q - 1'b1;
                    end
                end
            end
            if (fall && phase_q == PH_DATA && rd_q)
                out_q <= bit_pick(rdata, cnt_q, lsb_first);
        end
    end

    assign addr      = addr_q;
    assign wdata     = nxt_byte;
    assign rd_active = (phase_q == PH_DATA) && rd_q;
    assign out_bit   = out_q;

    // R9: chip select high returns the port to a fresh instruction
    a_r9_abort_to_instr: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (phase_q == PH_INSTR && cnt_q == '0));
    // R11: once the counted bytes are done, nothing restarts until deselect
    a_r11_done_holds: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DONE && !cs_n) |=> phase_q == PH_DONE);
    // R7: read data only moves after a serial clock falling edge
    a_r7_out_on_fall: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(out_q));

endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       sdio_in,
    output logic       sdio_out,
    output logic       sdio_oe,
    output logic       sdo,
    output logic [1:0] interp_rate,
    output logic [1:0] mod_mode,
    output logic       data_binary,
    output logic       one_port
);
    logic              rise, fall;
    logic              we;
    logic [ADDR_W-1:0] addr;
    byte_t             wdata, rdata;
    logic              rd_active, out_bit;
    cfg_t              cfg;

    spi_cfg_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .cs_n (cs_n),
        .rise (rise),
        .fall (fall)
    );

    spi_cfg_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .rise      (rise),
        .fall      (fall),
        .sdio_in   (sdio_in),
        .lsb_first (cfg.lsb_first),
        .rdata     (rdata),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .rd_active (rd_active),
        .out_bit   (out_bit)
    );

    spi_cfg_regs #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (addr),
        .wdata (wdata),
        .raddr (addr),
        .rdata (rdata),
        .cfg   (cfg)
    );

    assign sdio_out    = out_bit;
    assign sdio_oe     = rd_active && cfg.bidir && !cs_n;
    assign sdo         = (rd_active && !cfg.bidir && !cs_n) ? out_bit : 1'b0;
    assign interp_rate = cfg.interp;
    assign mod_mode    = cfg.modsel;
    assign data_binary = cfg.binary;
    assign one_port    = cfg.one_port;

    // R8: the shared line is never driven while the host is writing
    a_r8_no_drive_on_write: assert property (@(posedge clk) disable iff (rst)
        we |-> !sdio_oe);
    // R7: in four-wire mode the shared line stays an input
    a_r7_four_wire_quiet: assert property (@(posedge clk) disable iff (rst)
        !cfg.bidir |-> !sdio_oe);

endmodule

// File: tb/spi_cfg_port_tb.sv
module spi_cfg_port_tb;

    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo;
    logic [1:0] interp_rate, mod_mode;
    logic data_binary, one_port;

    always #4 clk = ~clk;

    spi_cfg_port u_dut (
        .clk         (clk),
        .rst         (rst),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .sdio_in     (sdio_in),
        .sdio_out    (sdio_out),
        .sdio_oe     (sdio_oe),
        .sdo         (sdo),
        .interp_rate (interp_rate),
        .mod_mode    (mod_mode),
        .data_binary (data_binary),
        .one_port    (one_port)
    );

    // scoreboard
    string nm_q[$];
    int    exp_q[$];
    int    act_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 0;

    // bench model of the port format
    bit lsb_mode = 0;
    bit bidir_mode = 0;

    task automatic push(input string nm, input int e, input int a);
        nm_q.push_back(nm);
        exp_q.push_back(e);
        act_q.push_back(a);
    endtask

    always @(posedge clk) begin
        while (act_q.size() > 0) begin
            string nm;
            int e, a;
            nm = nm_q.pop_front();
            e  = exp_q.pop_front();
            a  = act_q.pop_front();
            n_cmp++;
            if (a != e) begin
                n_bad++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", nm, a, e);
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_bit(input logic b, output logic rb, output logic oe, output logic so);
        sclk = 1'b0;
        sdio_in = b;
        wait_n(HALF);
        rb = bidir_mode ? sdio_out : sdo;
        oe = sdio_oe;
        so = sdo;
        sclk = 1'b1;
        wait_n(HALF);
    endtask

    task automatic xfer_byte(input logic [7:0] v, output logic [7:0] r,
                             output logic oe_all, output logic oe_any, output logic so_any);
        r = '0; oe_all = 1'b1; oe_any = 1'b0; so_any = 1'b0;
        for (int i = 0; i < 8; i++) begin
            int idx;
            logic rb, oe, so;
            idx = lsb_mode ? i : 7 - i;
            xfer_bit(v[idx], rb, oe, so);
            r[idx] = rb;
            oe_all &= oe;
            oe_any |= oe;
            so_any |= so;
        end
    endtask

    task automatic cs_begin();
        @(negedge clk);
        cs_n = 1'b0;
        wait_n(2);
    endtask

    task automatic cs_end();
        sclk = 1'b0;
        wait_n(HALF);
        cs_n = 1'b1;
        wait_n(4);
    endtask

    // sends instruction and 'sent' data bytes; n is the counted length
    task automatic spi_write(input logic [4:0] a, input int n, input int sent,
                             input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        logic [7:0] r, d;
        logic x0, x1, x2;
        logic [4:0] cur;
        cur = a;
        cs_begin();
        xfer_byte({1'b0, 2'(n - 1), a}, r, x0, x1, x2);
        for (int k = 0; k < sent; k++) begin
            d = (k == 0) ? b0 : (k == 1) ? b1 : b2;
            xfer_byte(d, r, x0, x1, x2);
            if (k < n) begin
                if (cur == 5'd0) begin
                    lsb_mode = d[6];
                    bidir_mode = d[7];
                end
                cur = lsb_mode ? cur + 5'd1 : cur - 5'd1;
            end
        end
        cs_end();
    endtask

    task automatic spi_read(input string req, input logic [4:0] a, input int n,
                            input logic [7:0] e0, input logic [7:0] e1);
        logic [7:0] r;
        logic oe_all, oe_any, so_any;
        cs_begin();
        xfer_byte({1'b1, 2'(n - 1), a}, r, oe_all, oe_any, so_any);
        for (int k = 0; k < n; k++) begin
            xfer_byte(8'h00, r, oe_all, oe_any, so_any);
            push({req, " read data"}, (k == 0) ? e0 : e1, r);
            push({req, " sdio_oe during data"}, bidir_mode ? 3 : 0, {oe_all, oe_any});
            if (bidir_mode) push({req, " sdo quiet in bidirectional mode"}, 0, so_any);
        end
        cs_end();
        push({req, " sdio_oe released after deselect"}, 0, sdio_oe);
    endtask

    task automatic check_cfg(input string req, input int ir, input int mm, input int db, input int op);
        @(negedge clk);
        push({req, " interp_rate"}, ir, interp_rate);
        push({req, " mod_mode"}, mm, mod_mode);
        push({req, " data_binary"}, db, data_binary);
        push({req, " one_port"}, op, one_port);
    endtask

    task automatic partial_bits(input logic [7:0] v, input int nb);
        logic rb, oe, so;
        for (int i = 0; i < nb; i++) xfer_bit(v[7 - i], rb, oe, so);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic x0, x1, x2;
        wait_n(5);
        rst = 1'b0;
        wait_n(2);

        // R1: reset state
        check_cfg("R1", 0, 0, 0, 0);
        push("R1 sdio_oe", 0, sdio_oe);
        push("R1 sdo", 0, sdo);

        // R2: single write to register 1
        spi_write(5'd1, 1, 1, 8'hB4, 8'h00, 8'h00);
        check_cfg("R2", 2, 3, 0, 0);

        // R4, R3: two-byte MSB-first write, address 2 then 1
        spi_write(5'd2, 2, 2, 8'hC0, 8'h5A, 8'h00);
        check_cfg("R4 R3", 1, 1, 1, 1);

        // R7: four-wire read back with decrementing address
        spi_read("R7 R4", 5'd2, 2, 8'hC0, 8'h5A);

        // R10: out-of-bank write ignored, read returns zero
        spi_write(5'd5, 1, 1, 8'hFF, 8'h00, 8'h00);
        check_cfg("R10", 1, 1, 1, 1);
        spi_read("R10 oob", 5'd5, 1, 8'h00, 8'h00);
        spi_read("R10 reg1", 5'd1, 1, 8'h5A, 8'h00);

        // R11: extra byte after the count is ignored
        spi_write(5'd3, 1, 2, 8'h11, 8'h22, 8'h00);
        spi_read("R11", 5'd3, 2, 8'h11, 8'hC0);

        // R9: aborted instruction, then a clean write, then aborted data
        cs_begin();
        partial_bits(8'h03, 5);
        cs_end();
        spi_write(5'd3, 1, 1, 8'h33, 8'h00, 8'h00);
        cs_begin();
        xfer_byte(8'h03, r, x0, x1, x2);
        partial_bits(8'hFF, 4);
        cs_end();
        spi_read("R9", 5'd3, 1, 8'h33, 8'h00);

        // R6: switch to LSB-first inside a two-byte write at address 0
        spi_write(5'd0, 2, 2, 8'h40, 8'h99, 8'h00);
        check_cfg("R6", 2, 1, 1, 1);

        // R5: LSB-first write and read with incrementing address
        spi_write(5'd2, 2, 2, 8'h80, 8'h4C, 8'h00);
        check_cfg("R5 R3", 2, 1, 1, 0);
        spi_read("R5", 5'd2, 2, 8'h80, 8'h4C);

        // R8: bidirectional read
        spi_write(5'd0, 1, 1, 8'hC0, 8'h00, 8'h00);
        spi_read("R8", 5'd3, 1, 8'h4C, 8'h00);

        // R7: back to MSB-first four-wire
        spi_write(5'd0, 1, 1, 8'h00, 8'h00, 8'h00);
        spi_read("R7 restore", 5'd1, 1, 8'h99, 8'h00);

        wait_n(4);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule